// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Manager

This block sits on the controller side of a synchronous DRAM interface. It owns refresh timing and the clock-enable (CKE) pin. An interval timer marks when a refresh falls due, and a small counter records how many refreshes are owed. The access engine can defer those refreshes while it is busy. Once the engine reports that it is idle, the manager takes the command bus. If any bank is still open it closes all banks with a precharge-all. It then issues the auto-refresh. The memory picks the rows and precharges itself afterwards, so no address and no trailing precharge are produced.

On request the manager also places the memory in power-down or self-refresh. Power-down is entered only from an idle, fully precharged state with no refresh owed. It is left as soon as a refresh falls due, so the owed refresh is never missed. Self-refresh entry always follows directly on a refresh the manager has just completed. On exit, one refresh is owed at once, so distributed refresh resumes inside a single interval. Commands are encoded on a 3-bit bus: NOP=0, precharge-all=1, auto-refresh=2, self-refresh entry=3, self-refresh exit=4. All outputs come from registers.

Top module: `sdram_refpwr_mgr`

## Requirements
- R1: While reset is held, cmd_o is NOP (0), cke_o is 1, and busy_o, ref_due_o and ref_urgent_o are 0.
- R2: Outside self-refresh the interval timer adds one owed refresh every REFI clock cycles. The first one is visible on ref_due_o after the REFI-th rising edge following reset release.
- R3: While eng_idle_i stays low, owed refreshes accumulate. ref_urgent_o is high once POSTPONE_MAX are owed, and the count saturates there.
- R4: When eng_idle_i is sampled high while refresh is needed and any bit of bank_open_i is set, precharge-all (1) is issued on the next cycle and auto-refresh (2) follows exactly TRP cycles later.
- R5: With all banks closed, a needed refresh is issued as auto-refresh (2) on the cycle after eng_idle_i is sampled high. No precharge-all is issued, and no further command comes before TRFC cycles have passed.
- R6: Each auto-refresh retires one owed refresh. ref_due_o falls once none remain.
- R7: With sr_req_i held, the manager first issues an auto-refresh. TRFC cycles later it issues self-refresh entry (3) with cke_o low, provided no refresh is owed and no interval expires on that cycle.
- R8: When sr_req_i falls during self-refresh, self-refresh exit (4) is issued with cke_o high on the next cycle, and one refresh is owed at once. busy_o falls TXSR cycles after the exit, and the owed refresh is issued on the following cycle if eng_idle_i is high.
- R9: Power-down (cke_o low, NOP on cmd_o) is entered only from idle with eng_idle_i and pd_req_i high, all banks closed, and no refresh owed or requested.
- R10: Power-down ends with cke_o high when pd_req_i falls, a refresh becomes owed, or sr_req_i rises. The cycle that raises cke_o carries NOP, and the owed refresh follows.
- R11: busy_o is high in every cycle in which the manager owns the command bus, and in particular whenever cke_o is low.
- R12: The interval timer is held while in self-refresh, so no refresh becomes owed there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open_i | input | NBANK | One bit per bank, high while that bank has an open row |
| eng_idle_i | input | 1 | Access engine is idle and yields the command bus |
| sr_req_i | input | 1 | Level request to hold the memory in self-refresh |
| pd_req_i | input | 1 | Level request to hold the memory in power-down |
| cmd_o | output | 3 | Command: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 self-refresh entry, 4 self-refresh exit |
| cke_o | output | 1 | Clock enable to the memory |
| busy_o | output | 1 | Manager owns the command bus |
| ref_due_o | output | 1 | At least one refresh is owed |
| ref_urgent_o | output | 1 | POSTPONE_MAX refreshes owed; engine must yield |

## Verification
The bench builds the manager with REFI=40, TRP=2, TRFC=4, TXSR=3 and POSTPONE_MAX=3, in place of the production interval of 1560 cycles. With these values, saturation of the deferral counter, a chain of back-to-back refreshes, power-down interrupted by several interval expiries, and a self-refresh stay longer than three intervals all fit in about a thousand cycles. The short wait counts also let a single run reach every wait-counter boundary, including a refresh forced just before self-refresh entry.

// File: rtl/refpwr_pkg.sv
package refpwr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PALL = 3'd1,
    CMD_AREF = 3'd2,
    CMD_SRE  = 3'd3,
    CMD_SRX  = 3'd4
  } sdcmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_REF  = 3'd2,
    ST_PD   = 3'd3,
    ST_SR   = 3'd4,
    ST_SRX  = 3'd5
  } mgr_st_e;

endpackage

// File: rtl/rfp_interval_timer.sv
module rfp_interval_timer #(
  parameter int REFI = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic tick_o
);

  localparam int CW = (REFI > 2) ? $clog2(REFI) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = !hold_i && (cnt_q == CW'(REFI - 1));

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R12: counter stays cleared while held for self-refresh
  a_r12_hold_clears: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (cnt_q == '0));

  // R2: an expiry is never followed by another on the next cycle
  a_r2_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/rfp_debt.sv
module rfp_debt #(
  parameter int MAXD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic retire_i,
  input  logic load_one_i,
  output logic due_o,
  output logic urgent_o
);

  localparam int DW = $clog2(MAXD + 1);

  logic [DW-1:0] owed_q;
  logic [DW:0]   sum;

  always_comb begin
    sum = {1'b0, owed_q} + {{DW{1'b0}}, tick_i};
    if (retire_i && (sum != '0)) begin
      sum = sum - (DW+1)'(1);
    end
    if (sum > (DW+1)'(MAXD)) begin
      sum = (DW+1)'(MAXD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
    end else if (load_one_i) begin
      owed_q <= DW'(1);
    end else begin
      owed_q <= sum[DW-1:0];
    end
  end

  assign due_o    = (owed_q != '0);
  assign urgent_o = (owed_q >= DW'(MAXD));

  // R3: saturated debt stays saturated until a refresh retires it
  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    ((owed_q == DW'(MAXD)) && !retire_i && !load_one_i) |=> (owed_q == DW'(MAXD)));

  // R6: a retired refresh lowers the debt by one
  a_r6_retire: assert property (@(posedge clk) disable iff (rst)
    (retire_i && !tick_i && !load_one_i && (owed_q != '0))
      |=> (owed_q == $past(owed_q) - 1'b1));

endmodule

// File: rtl/rfp_seq.sv
module rfp_seq
  import refpwr_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int TRP   = 2,
  parameter int TRFC  = 7,
  parameter int TXSR  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBANK-1:0] bank_open_i,
  input  logic             gnt_i,
  input  logic             sr_req_i,
  input  logic             pd_req_i,
  input  logic             due_i,
  input  logic             tick_i,
  output sdcmd_e           cmd_o,
  output logic             cke_o,
  output logic             busy_o,
  output logic             retire_o,
  output logic             load_one_o,
  output logic             hold_o
);

  localparam int WMAX = (TRP > TRFC) ? ((TRP > TXSR) ? TRP : TXSR)
                                     : ((TRFC > TXSR) ? TRFC : TXSR);
  localparam int WW   = $clog2(WMAX + 1);

  mgr_st_e       state_q, st_n;
  logic [WW-1:0] wcnt_q, wc_n;
  sdcmd_e        cmd_q, cmd_n;
  logic          cke_q, cke_n;
  logic          retire;
  logic          banks_closed, need_ref, wdone;

  assign banks_closed = (bank_open_i == '0);
  assign need_ref     = due_i || sr_req_i;
  assign wdone        = (wcnt_q == '0);

  always_comb begin
    st_n   = state_q;
    wc_n   = wcnt_q;
    cmd_n  = CMD_NOP;
    cke_n  = cke_q;
    retire = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (gnt_i) begin
          if (need_ref) begin
            if (!banks_closed) begin
              cmd_n = CMD_PALL;
              st_n  = ST_PRE;
              wc_n  = WW'(TRP - 1);
            end else begin
              cmd_n  = CMD_AREF;
              st_n   = ST_REF;
              wc_n   = WW'(TRFC - 1);
              retire = 1'b1;
            end
          end else if (pd_req_i && banks_closed) begin
            cke_n = 1'b0;
            st_n  = ST_PD;
          end
        end
      end
      ST_PRE: begin
        if (wdone) begin
          cmd_n  = CMD_AREF;
          st_n   = ST_REF;
          wc_n   = WW'(TRFC - 1);
          retire = 1'b1;
        end else begin
          wc_n = wcnt_q - 1'b1;
        end
      end
      ST_REF: begin
        if (wdone) begin
          if (sr_req_i && !due_i && !tick_i) begin
            cmd_n = CMD_SRE;
            cke_n = 1'b0;
            st_n  = ST_SR;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          wc_n = wcnt_q - 1'b1;
        end
      end
      ST_PD: begin
        if (due_i || sr_req_i || !pd_req_i) begin
          cke_n = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      ST_SR: begin
        if (!sr_req_i) begin
          cmd_n = CMD_SRX;
          cke_n = 1'b1;
          st_n  = ST_SRX;
          wc_n  = WW'(TXSR - 1);
        end
      end
      ST_SRX: begin
        if (wdone) begin
          st_n = ST_IDLE;
        end else begin
          wc_n = wcnt_q - 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      cmd_q   <= CMD_NOP;
      cke_q   <= 1'b1;
    end else begin
      state_q <= st_n;
      wcnt_q  <= wc_n;
      cmd_q   <= cmd_n;
      cke_q   <= cke_n;
    end
  end

  assign cmd_o      = cmd_q;
  assign cke_o      = cke_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign retire_o   = retire;
  assign hold_o     = (state_q == ST_SR);
  assign load_one_o = (state_q == ST_SR) && !sr_req_i;

  // R4: a refresh goes out only after a precharge-all or with all banks closed
  a_r4_pall_first: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_AREF) |-> (($past(state_q) == ST_PRE) || ($past(bank_open_i) == '0)));

  // R7: self-refresh entry carries CKE low
  a_r7_sre_cke_low: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_SRE) |-> (!cke_q && (state_q == ST_SR)));

  // R8: self-refresh exit raises CKE
  a_r8_srx_cke_rise: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_SRX) |-> (cke_q && !$past(cke_q)));

  // R9: power-down only from idle with banks closed and no debt
  a_r9_pd_entry: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_PD) && ($past(state_q) == ST_IDLE))
      |-> (($past(bank_open_i) == '0) && !$past(due_i)));

  // R10: the cycle leaving power-down carries no command
  a_r10_pd_exit_quiet: assert property (@(posedge clk) disable iff (rst)
    ($rose(cke_q) && ($past(state_q) == ST_PD)) |-> (cmd_q == CMD_NOP));

  // R11: CKE low implies ownership of the bus
  a_r11_busy_when_low: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> busy_o);

endmodule

// File: rtl/sdram_refpwr_mgr.sv
module sdram_refpwr_mgr
  import refpwr_pkg::*;
#(
  parameter int NBANK        = 4,
  parameter int REFI         = 1560,
  parameter int TRP          = 2,
  parameter int TRFC         = 7,
  parameter int TXSR         = 8,
  parameter int POSTPONE_MAX = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBANK-1:0] bank_open_i,
  input  logic             eng_idle_i,
  input  logic             sr_req_i,
  input  logic             pd_req_i,
  output logic [2:0]       cmd_o,
  output logic             cke_o,
  output logic             busy_o,
  output logic             ref_due_o,
  output logic             ref_urgent_o
);

  logic   tick, hold, retire, load_one, due, urgent;
  sdcmd_e cmd;

  rfp_interval_timer #(.REFI(REFI)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .hold_i (hold),
    .tick_o (tick)
  );

  rfp_debt #(.MAXD(POSTPONE_MAX)) u_debt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .retire_i   (retire),
    .load_one_i (load_one),
    .due_o      (due),
    .urgent_o   (urgent)
  );

  rfp_seq #(
    .NBANK (NBANK),
    .TRP   (TRP),
    .TRFC  (TRFC),
    .TXSR  (TXSR)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .bank_open_i (bank_open_i),
    .gnt_i       (eng_idle_i),
    .sr_req_i    (sr_req_i),
    .pd_req_i    (pd_req_i),
    .due_i       (due),
    .tick_i      (tick),
    .cmd_o       (cmd),
    .cke_o       (cke_o),
    .busy_o      (busy_o),
    .retire_o    (retire),
    .load_one_o  (load_one),
    .hold_o      (hold)
  );

  assign cmd_o        = cmd;
  assign ref_due_o    = due;
  assign ref_urgent_o = urgent;

endmodule

// File: tb/sdram_refpwr_mgr_tb.sv
module sdram_refpwr_mgr_tb;

  localparam int NBANK = 4;
  localparam int REFI  = 40;
  localparam int TRP   = 2;
  localparam int TRFC  = 4;
  localparam int TXSR  = 3;
  localparam int PMAX  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NBANK-1:0] bank = '0;
  logic gnt = 1'b0, srq = 1'b0, pdq = 1'b0;
  logic [2:0] cmd;
  logic cke, busy, due, urgent;

  always #10 clk = ~clk;

  sdram_refpwr_mgr #(
    .NBANK(NBANK), .REFI(REFI), .TRP(TRP), .TRFC(TRFC), .TXSR(TXSR), .POSTPONE_MAX(PMAX)
  ) u_dut (
    .clk(clk), .rst(rst), .bank_open_i(bank), .eng_idle_i(gnt),
    .sr_req_i(srq), .pd_req_i(pdq), .cmd_o(cmd), .cke_o(cke),
    .busy_o(busy), .ref_due_o(due), .ref_urgent_o(urgent)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  // behavioural reference: mode names as integers
  // 0 idle, 1 closing banks, 2 refreshing, 3 power-down, 4 self-refresh, 5 leaving self-refresh
  int m_mode = 0, m_wait = 0, m_owed = 0, m_timer = 0, m_cmd = 0;
  bit m_cke = 1, m_valid = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_wait = 0; m_owed = 0; m_timer = 0; m_cmd = 0; m_cke = 1;
      m_valid = 1;
    end else begin
      int expire, take, fresh, tot;
      expire = (m_mode != 4 && m_timer == REFI - 1) ? 1 : 0;
      take = 0; fresh = 0; m_cmd = 0;
      if (m_mode == 0) begin
        if (gnt && (m_owed > 0 || srq)) begin
          if (bank != 0) begin m_cmd = 1; m_mode = 1; m_wait = TRP; end
          else begin m_cmd = 2; m_mode = 2; m_wait = TRFC; take = 1; end
        end else if (gnt && pdq && bank == 0) begin
          m_cke = 0; m_mode = 3;
        end
      end else if (m_mode == 1) begin
        m_wait--;
        if (m_wait == 0) begin m_cmd = 2; m_mode = 2; m_wait = TRFC; take = 1; end
      end else if (m_mode == 2) begin
        m_wait--;
        if (m_wait == 0) begin
          if (srq && m_owed == 0 && !expire) begin m_cmd = 3; m_cke = 0; m_mode = 4; end
          else m_mode = 0;
        end
      end else if (m_mode == 3) begin
        if (m_owed > 0 || srq || !pdq) begin m_cke = 1; m_mode = 0; end
      end else if (m_mode == 4) begin
        if (!srq) begin m_cmd = 4; m_cke = 1; m_mode = 5; m_wait = TXSR; fresh = 1; end
      end else begin
        m_wait--;
        if (m_wait == 0) m_mode = 0;
      end
      if (m_mode == 4 && m_cmd != 3) m_timer = 0;
      else if (fresh == 1) m_timer = 0;
      else if (expire == 1) m_timer = 0;
      else m_timer++;
      if (fresh == 1) m_owed = 1;
      else begin
        tot = m_owed + expire;
        if (take == 1 && tot > 0) tot--;
        if (tot > PMAX) tot = PMAX;
        m_owed = tot;
      end
    end
  end

  function automatic string cmd_tag(input int c);
    case (c)
      1: return "R4";
      2: return "R5";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  int n_aref = 0, n_pall = 0, n_sre = 0;

  always @(negedge clk) begin
    if (m_valid && !rst && !done) begin
      check(int'(cmd) == m_cmd, cmd_tag(m_cmd), int'(cmd), m_cmd);
      check(cke == m_cke, "R9 cke", int'(cke), int'(m_cke));
      check(busy == (m_mode != 0), "R11", int'(busy), int'(m_mode != 0));
      check(due == (m_owed > 0), "R6", int'(due), int'(m_owed > 0));
      check(urgent == (m_owed >= PMAX), "R3", int'(urgent), int'(m_owed >= PMAX));
      if (cmd == 3'd2) n_aref++;
      if (cmd == 3'd1) n_pall++;
      if (cmd == 3'd3) n_sre++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int a0, p0, s0;
    step(3);
    // R1: reset values
    check(cmd == 3'd0, "R1 cmd", int'(cmd), 0);
    check(cke == 1'b1, "R1 cke", int'(cke), 1);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(due == 1'b0, "R1 due", int'(due), 0);
    check(urgent == 1'b0, "R1 urgent", int'(urgent), 0);
    #1 rst = 1'b0;

    // R2: first interval expiry
    step(REFI - 1);
    check(due == 1'b0, "R2 before interval", int'(due), 0);
    step(1);
    check(due == 1'b1, "R2 at interval", int'(due), 1);

    // R3: deferral up to the limit
    step(3 * REFI);
    check(urgent == 1'b1, "R3 urgent", int'(urgent), 1);
    step(REFI);
    check(urgent == 1'b1 && busy == 1'b0, "R3 saturated", int'(urgent), 1);

    // R4: open bank forces precharge-all first
    #1 begin gnt = 1'b1; bank = 4'b0100; end
    step(1);
    check(cmd == 3'd1, "R4 precharge-all", int'(cmd), 1);
    #1 bank = '0;
    step(TRP);
    check(cmd == 3'd2, "R4 refresh after TRP", int'(cmd), 2);
    step(25);
    check(due == 1'b0, "R6 debt cleared", int'(due), 0);

    // R5: distributed refresh with banks closed
    a0 = n_aref; p0 = n_pall;
    step(2 * REFI);
    check(n_aref - a0 == 2, "R5 refresh count", n_aref - a0, 2);
    check(n_pall == p0, "R5 no precharge", n_pall - p0, 0);

    // R9 / R10: power-down interrupted by expiries
    #1 pdq = 1'b1;
    step(2);
    check(cke == 1'b0 && busy == 1'b1, "R9 in power-down", int'(cke), 0);
    a0 = n_aref;
    step(2 * REFI);
    check(n_aref - a0 >= 1, "R10 refresh during power-down", n_aref - a0, 2);
    #1 pdq = 1'b0;
    step(3);
    check(cke == 1'b1 && busy == 1'b0, "R10 left power-down", int'(cke), 1);

    // R7: self-refresh entry behind a forced refresh
    s0 = n_sre; a0 = n_aref;
    #1 srq = 1'b1;
    step(20);
    check(cke == 1'b0 && busy == 1'b1, "R7 in self-refresh", int'(cke), 0);
    check(n_sre - s0 == 1 && n_aref - a0 == 1, "R7 entry sequence", n_sre - s0, 1);

    // R12: no debt during a long stay
    step(3 * REFI);
    check(due == 1'b0 && urgent == 1'b0, "R12 no debt", int'(due), 0);

    // R8: exit and prompt refresh
    #1 srq = 1'b0;
    step(1);
    check(cmd == 3'd4 && cke == 1'b1, "R8 exit command", int'(cmd), 4);
    check(due == 1'b1, "R8 refresh owed", int'(due), 1);
    step(TXSR + 1);
    check(cmd == 3'd2, "R8 refresh after exit", int'(cmd), 2);
    step(60);

    done = 1;
    summary();
    $finish;
  end

endmodule